// File: doc/BRIEF.md
# Sigma-Delta Density Decimator

This block turns the single-bit output of a sigma-delta modulator into multi-bit amplitude samples. The density of 1s in the incoming stream stands for the analog level. The block counts the 1s over consecutive windows of a fixed number of accepted bits. At the end of each window it emits the count as the amplitude code for that interval and pulses a valid strobe for one cycle.

Each sample is also given as a signed, offset-removed value. A window that is half 1s reads zero. A window of only 1s reads full-scale positive, and a window with no 1s reads full-scale negative. An input qualifier marks the cycles that carry a modulator bit. Only those cycles advance the window, so the block can sit behind a modulator that runs slower than the system clock.

Top module: `sd_density_decimator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `sample_o`, `sample_signed_o` and `valid_o` to zero on that edge.
- R2: A window holds exactly `WINDOW_LEN` accepted bits. A bit is accepted on a clock edge where `bit_en` is 1. On an edge where `bit_en` is 0, `bit_in` is ignored and the window does not advance.
- R3: `sample_o` is the number of 1s among the accepted bits of the window just closed, including its final bit. It is an unsigned value of width clog2(`WINDOW_LEN`+1), so a window of only 1s gives `WINDOW_LEN` and a window with no 1s gives 0.
- R4: `valid_o` is 1 for exactly one cycle. That cycle directly follows the edge that accepts a window's final bit, and `sample_o` and `sample_signed_o` take the new values on that same edge.
- R5: Between window closings, `sample_o` and `sample_signed_o` hold their last values.
- R6: `sample_signed_o` is the two's-complement value of (count − `WINDOW_LEN`/2), one bit wider than `sample_o`. It reads +`WINDOW_LEN`/2 for a window of only 1s, 0 for a window that is exactly half 1s, and −`WINDOW_LEN`/2 for a window with no 1s.
- R7: Windows follow each other with no gap and no lost bit. The first bit accepted after a window's final bit is the first bit of the next window, even when it arrives on the cycle right after the final bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Modulator bit |
| bit_en | input | 1 | 1 when `bit_in` carries a bit to accept |
| sample_o | output | clog2(WINDOW_LEN+1) | Count of 1s in the last window |
| sample_signed_o | output | clog2(WINDOW_LEN+1)+1 | Count minus WINDOW_LEN/2, two's complement |
| valid_o | output | 1 | One-cycle strobe when a new sample is out |

## Verification
Four properties are checked on every clock by the assertions. The first is that the strobe lands exactly one edge after the final bit of a window, and never on two cycles in a row. The second is that each emitted count equals an independent tally of the accepted 1s. The third is that the outputs hold between strobes and the signed output always tracks the count minus half the window. The fourth is that the count never exceeds the window length. Only the bench scenarios show the density extremes, the half-density zero point, windows with bits withheld by the qualifier, and a long irregular stream with back-to-back windows.

// File: rtl/sdd_pkg.sv
// Package sdd_pkg
// Shared width helpers for the sigma-delta density decimator.
// Assumes window lengths are positive and small enough for 32-bit math.
package sdd_pkg;

    // Bits needed to hold any value from 0 up to and including n
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Bits needed for a position index from 0 to n-1 (at least 1)
    function automatic int index_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sdd_window_timer.sv
// Module sdd_window_timer
// Tracks the position of the current accepted bit inside a window.
// Flags the step that accepts the final bit of the window.
// Assumes WINDOW_LEN >= 2. The position advances only when step_i is 1.
module sdd_window_timer #(
    parameter int WINDOW_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic last_o
);
    localparam int IDX_W = sdd_pkg::index_width(WINDOW_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW_LEN - 1);

    logic [IDX_W-1:0] pos_q;

    // Final-bit flag: an accepted bit in the last slot of the window
    always_comb begin
        last_o = step_i && (pos_q == LAST_IDX);
    end

    // Position counter: wrap to zero after the final slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (step_i) begin
            if (pos_q == LAST_IDX) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdd_ones_accum.sv
// Module sdd_ones_accum
// Counts accepted 1s within the current window.
// total_o shows the count including the bit being accepted this cycle.
// When close_i is 1 the accumulator restarts from zero.
// Assumes close_i is only asserted together with step_i.
module sdd_ones_accum #(
    parameter int WINDOW_LEN = 16,
    parameter int CNT_W      = sdd_pkg::count_width(WINDOW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             bit_i,
    input  logic             close_i,
    output logic [CNT_W-1:0] total_o
);
    logic [CNT_W-1:0] acc_q;

    // Running total with the current bit folded in
    always_comb begin
        total_o = acc_q + CNT_W'(step_i & bit_i);
    end

    // Accumulator: add accepted bits, clear at a window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_i) begin
            if (close_i) begin
                acc_q <= '0;
            end else begin
                acc_q <= total_o;
            end
        end
    end

endmodule

// File: rtl/sdd_output_stage.sv
// Module sdd_output_stage
// Registers the finished window count, its offset-removed signed form
// and a one-cycle valid strobe. The outputs hold between loads.
// Assumes WINDOW_LEN is even so that half the window is a whole count.
module sdd_output_stage #(
    parameter int WINDOW_LEN = 16,
    parameter int CNT_W      = sdd_pkg::count_width(WINDOW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] total_i,
    output logic [CNT_W-1:0] sample_o,
    output logic [CNT_W:0]   signed_o,
    output logic             valid_o
);
    localparam int SGN_W = CNT_W + 1;
    localparam logic [SGN_W-1:0] HALF_V = SGN_W'(WINDOW_LEN / 2);

    logic [SGN_W-1:0] centred;

    // Offset removal: count minus half the window, two's complement
    always_comb begin
        centred = {1'b0, total_i} - HALF_V;
    end

    // Output registers: capture on load, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            signed_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                sample_o <= total_i;
                signed_o <= centred;
            end
        end
    end

endmodule

// File: rtl/sd_density_decimator.sv
// Module sd_density_decimator
// Count-and-dump decimator for a 1-bit sigma-delta stream. Each window of
// WINDOW_LEN accepted bits yields one unsigned count of 1s and one signed
// value centred on half the window, with a one-cycle valid strobe.
// Assumes WINDOW_LEN is even and at least 2. Reset is synchronous, active low.
module sd_density_decimator #(
    parameter int WINDOW_LEN = 16,
    localparam int CNT_W     = sdd_pkg::count_width(WINDOW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_en,
    output logic [CNT_W-1:0] sample_o,
    output logic [CNT_W:0]   sample_signed_o,
    output logic             valid_o
);
    logic             win_last;
    logic [CNT_W-1:0] win_total;

    sdd_window_timer #(
        .WINDOW_LEN(WINDOW_LEN)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (bit_en),
        .last_o (win_last)
    );

    sdd_ones_accum #(
        .WINDOW_LEN(WINDOW_LEN),
        .CNT_W     (CNT_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (bit_en),
        .bit_i   (bit_in),
        .close_i (win_last),
        .total_o (win_total)
    );

    sdd_output_stage #(
        .WINDOW_LEN(WINDOW_LEN),
        .CNT_W     (CNT_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (win_last),
        .total_i  (win_total),
        .sample_o (sample_o),
        .signed_o (sample_signed_o),
        .valid_o  (valid_o)
    );

endmodule

// File: rtl/sdd_checker.sv
// Module sdd_checker
// Property checker for sd_density_decimator, attached through bind.
// Keeps its own tally of accepted bits and 1s to judge window closings.
module sdd_checker #(
    parameter int WINDOW_LEN = 16,
    localparam int CNT_W     = sdd_pkg::count_width(WINDOW_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_in,
    input logic             bit_en,
    input logic [CNT_W-1:0] sample_o,
    input logic [CNT_W:0]   sample_signed_o,
    input logic             valid_o
);
    localparam int TALLY_W = 32;

    logic [TALLY_W-1:0] seen_q;
    logic [TALLY_W-1:0] ones_q;
    logic [TALLY_W-1:0] last_q;
    logic               done_q;

    // Independent tally of accepted bits and 1s per window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            ones_q <= '0;
            last_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bit_en) begin
                if (seen_q == TALLY_W'(WINDOW_LEN - 1)) begin
                    done_q <= 1'b1;
                    last_q <= ones_q + TALLY_W'(bit_in);
                    seen_q <= '0;
                    ones_q <= '0;
                end else begin
                    seen_q <= seen_q + 1;
                    ones_q <= ones_q + TALLY_W'(bit_in);
                end
            end
        end
    end

    AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == done_q); // R4

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R4

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (TALLY_W'(sample_o) == last_q)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o <= CNT_W'(WINDOW_LEN)); // R3

    AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && $past(rst_n)) |-> ($stable(sample_o) && $stable(sample_signed_o))); // R5

    AST_SIGNED_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($signed(sample_signed_o) == $signed({1'b0, sample_o}) - $signed((CNT_W+1)'(WINDOW_LEN / 2)))); // R6

endmodule

bind sd_density_decimator sdd_checker #(
    .WINDOW_LEN(WINDOW_LEN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bit_in          (bit_in),
    .bit_en          (bit_en),
    .sample_o        (sample_o),
    .sample_signed_o (sample_signed_o),
    .valid_o         (valid_o)
);

// File: tb/sd_density_decimator_tb.sv
// Bench for sd_density_decimator: a behavioural per-cycle model plus
// fixed-pattern window checks with known densities.
module sd_density_decimator_tb;
    localparam int L     = 16;
    localparam int CNT_W = $clog2(L + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_in = 1'b0;
    logic             bit_en = 1'b0;
    logic [CNT_W-1:0] sample_o;
    logic [CNT_W:0]   sample_signed_o;
    logic             valid_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit summary_done = 1'b0;

    // model state
    int m_pos = 0;
    int m_ones = 0;
    int e_sample = 0;
    int e_signed = 0;
    int e_valid = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    sd_density_decimator #(.WINDOW_LEN(L)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_in          (bit_in),
        .bit_en          (bit_en),
        .sample_o        (sample_o),
        .sample_signed_o (sample_signed_o),
        .valid_o         (valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Per-cycle compare then drive one cycle of input and advance the model
    task automatic drive(input logic b, input logic en);
        @(negedge clk);
        if (model_on) begin
            check("R4 valid", int'(valid_o), e_valid);
            check(e_valid ? "R3 count" : "R5 hold", int'(sample_o), e_sample);
            check(e_valid ? "R6 signed" : "R5 hold signed", int'($signed(sample_signed_o)), e_signed);
        end
        bit_in = b;
        bit_en = en;
        e_valid = 0;
        if (en) begin
            if (m_pos == L - 1) begin
                e_sample = m_ones + int'(b);
                e_signed = e_sample - L / 2;
                e_valid = 1;
                m_pos = 0;
                m_ones = 0;
            end else begin
                m_pos++;
                m_ones += int'(b);
            end
        end
    endtask

    // Explicit check of a just-closed window against a known constant
    task automatic expect_window(input string req, input int cnt, input int sgn);
        @(posedge clk);
        #2;
        check({req, " strobe"}, int'(valid_o), 1);
        check({req, " count"}, int'(sample_o), cnt);
        check({req, " signed"}, int'($signed(sample_signed_o)), sgn);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        check("R1 sample", int'(sample_o), 0);
        check("R1 signed", int'(sample_signed_o), 0);
        check("R1 valid", int'(valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R3 R6: all ones gives full count, +L/2
        for (int i = 0; i < L; i++) drive(1'b1, 1'b1);
        expect_window("R3 R6 all ones", L, L / 2);
        // R3 R6 R7: all zeros right after, -L/2
        for (int i = 0; i < L; i++) drive(1'b0, 1'b1);
        expect_window("R6 all zeros", 0, -L / 2);
        // R6: alternating, half density reads zero
        for (int i = 0; i < L; i++) drive(logic'(i % 2), 1'b1);
        expect_window("R6 half density", L / 2, 0);
        // R3: one in four
        for (int i = 0; i < L; i++) drive(logic'(i % 4 == 0), 1'b1);
        expect_window("R3 quarter density", L / 4, L / 4 - L / 2);
        // R2: 1s offered with bit_en low are ignored
        for (int i = 0; i < L; i++) begin
            drive(1'b0, 1'b1);
            drive(1'b1, 1'b0);
            drive(1'b1, 1'b0);
        end
        drive(1'b0, 1'b0);
        check("R2 ignored ones count", int'(sample_o), 0);
        check("R2 no extra strobe", int'(valid_o), 0);
        // R2 R5: ones with gaps, outputs hold through gaps
        for (int i = 0; i < L; i++) begin
            drive(1'b1, 1'b1);
            if (i != L - 1) drive(1'b0, 1'b0);
        end
        expect_window("R2 gapped ones", L, L / 2);
        // R7: back-to-back windows, final bit then first bit of next
        for (int i = 0; i < L; i++) drive(logic'(i == L - 1), 1'b1);
        expect_window("R7 final bit kept", 1, 1 - L / 2);
        for (int i = 0; i < L; i++) drive(logic'(i == 0 || i == 1), 1'b1);
        expect_window("R7 next window first bits", 2, 2 - L / 2);

        // Irregular stream compared with the model every cycle (R2..R7)
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[3], !(lfsr[5] & lfsr[7]));
        end

        // R1: reset mid-window clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1 mid-run sample", int'(sample_o), 0);
        check("R1 mid-run valid", int'(valid_o), 0);
        finish_run();
    end

endmodule